// File: doc/BRIEF.md
# Power-Management Event Register Block with System Control Interrupt

This block is a small power-management register file reached through an I/O port window. It holds an event status word, an event enable word, a control word and a free-running timer. A level-sensitive system control interrupt (SCI) is raised while any of four tracked events is both latched in status and allowed by enable.

The tracked events are a timer carry, a global-lock request, a power-button press and a real-time-clock alarm. The last three arrive as single-cycle input pulses. The timer advances on a tick-enable input, and its carry out of the top bit latches the timer event. Firmware enables the events it wants, services the SCI and clears the latched bits by writing ones to them.

The window base and the decode enable come from configuration inputs that a neighbouring configuration-space block supplies. Sleep sequencing is not part of this block. The control word is plain storage.

Top module: `pm_event_block`

## Requirements
- R1: After reset the status, enable and control words and the timer are all zero, and `sciLevel` is low.
- R2: The block answers only while `cfgDecodeEn` is 1 and the access address falls in the 64-byte window whose base is `cfgIoBase & 16'hFFC0`. Any other access reads zero, and its writes change nothing.
- R3: Only `ioAddr[3:0]` picks a register. For 16-bit accesses (`ioWide`=0), offset 0x0 is status, 0x2 is enable and 0x4 is control. Window offsets 0x10 to 0x3F alias those same registers.
- R4: A 32-bit read (`ioWide`=1) at offset 0x8 returns the timer count, zero-extended to 32 bits. Every other read offset returns zero, and so does any 16-bit read at 0x8. A 16-bit read returns its register in bits 15:0 with bits 31:16 zero.
- R5: A 32-bit write has no effect on any register.
- R6: Status bits are set by events at fixed positions: bit 0 for timer carry, bit 5 for `evGlobalLock`, bit 8 for `evPwrBtn` and bit 10 for `evRtc`. All other status bits always read zero.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When an event arrives in the same cycle as a write that clears its bit, the event wins and the bit stays set.
- R8: The enable and control words store and read back all 16 written bits.
- R9: `sciLevel` is high exactly when status and enable share a set bit among bits 0, 5, 8 and 10. It reflects a status write, an enable write or an event from the clock edge that records it. Enable bits outside those four never raise it.
- R10: The timer is `TMR_W` bits wide (24 by default). It increments by one on each cycle with `tickEn` high, holds otherwise and wraps to zero. The wrapping increment sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgIoBase | input | 16 | Low half of the configured base dword; bits 5:0 are ignored |
| cfgDecodeEn | input | 1 | Window decode enable from configuration |
| ioAddr | input | 16 | I/O access address |
| ioWrEn | input | 1 | Write strobe, one cycle per access |
| ioRdEn | input | 1 | Read strobe; read data is combinational |
| ioWide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| ioWrData | input | 16 | Write data for 16-bit writes |
| ioRdData | output | 32 | Read data |
| evRtc | input | 1 | Real-time-clock alarm pulse |
| evPwrBtn | input | 1 | Power-button pulse |
| evGlobalLock | input | 1 | Global-lock release pulse |
| tickEn | input | 1 | Timer increment enable |
| sciLevel | output | 1 | Level system control interrupt |

## Verification
The bench aims at the cases where decode or priority is easy to get wrong:
- **Aliased offsets.** An access at window offset 0x12 must reach the enable word. A decoder that compares more address bits would silently drop the write.
- **Decode rules.** Accesses with decode off, or just past the window, must read zero and write nothing. The bench also moves the base to an unaligned value to show that the low six bits are masked.
- **Same-cycle event and clear.** A clear of a bit and an event on that bit land together; a design that gives the clear priority would lose the event.
- **SCI gating.** Enable bits outside the four SCI bits must not raise the SCI.
- **Timer carry.** The bench uses a narrow timer so it can wrap it; a wrong carry shows up as a missing timer status bit and a missing SCI.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  // Status / enable bit positions (R6, R9)
  localparam int STS_TMR_BIT = 0;
  localparam int STS_GBL_BIT = 5;
  localparam int STS_PWR_BIT = 8;
  localparam int STS_RTC_BIT = 10;

  localparam int REG_W = 16;
  localparam int BUS_W = 32;

  localparam logic [REG_W-1:0] SCI_MASK =
      (REG_W'(1) << STS_TMR_BIT) | (REG_W'(1) << STS_GBL_BIT) |
      (REG_W'(1) << STS_PWR_BIT) | (REG_W'(1) << STS_RTC_BIT);

  // Register offsets within the low four address bits (R3, R4)
  localparam logic [3:0] OFF_STS = 4'h0;
  localparam logic [3:0] OFF_EN  = 4'h2;
  localparam logic [3:0] OFF_CNT = 4'h4;
  localparam logic [3:0] OFF_TMR = 4'h8;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_STS  = 3'd1,
    RD_EN   = 3'd2,
    RD_CNT  = 3'd3,
    RD_TMR  = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   wrSts;
    logic   wrEn;
    logic   wrCnt;
    rdSel_e rdSel;
  } ioStrb_t;

endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 64,
  parameter int SEL_BITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgIoBase,
  input  logic              cfgDecodeEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic              ioWide,
  output ioStrb_t           strb
);

  localparam int WIN_LSB = $clog2(WIN_BYTES);
  localparam logic [ADDR_W-1:0] WIN_MASK = ~((ADDR_W'(1) << WIN_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] baseAddr;
  logic              winHit;
  logic [SEL_BITS-1:0] offSel;
  logic [WIN_LSB-SEL_BITS-1:0] unusedAliasBits;

  assign baseAddr = cfgIoBase & WIN_MASK;
  assign winHit   = cfgDecodeEn && ((ioAddr & WIN_MASK) == baseAddr);
  assign offSel   = ioAddr[SEL_BITS-1:0];
  assign unusedAliasBits = ioAddr[WIN_LSB-1:SEL_BITS];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (winHit) begin
      if (ioWrEn && !ioWide) begin
        case (offSel)
          OFF_STS: strb.wrSts = 1'b1;
          OFF_EN:  strb.wrEn  = 1'b1;
          OFF_CNT: strb.wrCnt = 1'b1;
          default: ;
        endcase
      end
      if (ioRdEn) begin
        if (ioWide) begin
          if (offSel == OFF_TMR) strb.rdSel = RD_TMR;
        end else begin
          case (offSel)
            OFF_STS: strb.rdSel = RD_STS;
            OFF_EN:  strb.rdSel = RD_EN;
            OFF_CNT: strb.rdSel = RD_CNT;
            default: strb.rdSel = RD_NONE;
          endcase
        end
      end
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSts, strb.wrEn, strb.wrCnt})); // R3

  AST_NO_DECODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDecodeEn |-> !(strb.wrSts || strb.wrEn || strb.wrCnt)); // R2

endmodule

// File: rtl/pm_evt_timer.sv
module pm_evt_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  output logic [TMR_W-1:0] count,
  output logic             ovfPulse
);

  assign ovfPulse = tickEn && (&count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       count <= '0;
    else if (tickEn) count <= count + TMR_W'(1);
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (count == $past(count) + TMR_W'(1))); // R10

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(count)); // R10

endmodule

// File: rtl/pm_evt_datapath.sv
module pm_evt_datapath
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ioStrb_t          strb,
  input  logic [REG_W-1:0] wrData,
  input  logic             evRtc,
  input  logic             evPwrBtn,
  input  logic             evGlobalLock,
  input  logic             tickEn,
  output logic [BUS_W-1:0] rdData,
  output logic             sciLevel
);

  localparam int TMR_PAD = BUS_W - TMR_W;
  localparam int REG_PAD = BUS_W - REG_W;

  logic [REG_W-1:0] stsReg, enReg, cntReg;
  logic [REG_W-1:0] evtSet, clrMask, stsNext;
  logic [TMR_W-1:0] tmrCount;
  logic             tmrOvf;

  pm_evt_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .count    (tmrCount),
    .ovfPulse (tmrOvf)
  );

  always_comb begin
    evtSet              = '0;
    evtSet[STS_TMR_BIT] = tmrOvf;
    evtSet[STS_GBL_BIT] = evGlobalLock;
    evtSet[STS_PWR_BIT] = evPwrBtn;
    evtSet[STS_RTC_BIT] = evRtc;
    clrMask = strb.wrSts ? wrData : '0;
    // events take priority over a same-cycle clear
    stsNext = (stsReg & ~clrMask) | evtSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsReg <= '0;
      enReg  <= '0;
      cntReg <= '0;
    end else begin
      stsReg <= stsNext;
      if (strb.wrEn)  enReg  <= wrData;
      if (strb.wrCnt) cntReg <= wrData;
    end
  end

  assign sciLevel = |(stsReg & enReg & SCI_MASK);

  always_comb begin
    case (strb.rdSel)
      RD_STS:  rdData = {{REG_PAD{1'b0}}, stsReg};
      RD_EN:   rdData = {{REG_PAD{1'b0}}, enReg};
      RD_CNT:  rdData = {{REG_PAD{1'b0}}, cntReg};
      RD_TMR:  rdData = {{TMR_PAD{1'b0}}, tmrCount};
      default: rdData = '0;
    endcase
  end

  AST_OVF_SETS_STS: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |=> stsReg[STS_TMR_BIT]); // R10

  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (evRtc && strb.wrSts) |=> stsReg[STS_RTC_BIT]); // R7

  AST_SCI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sciLevel) |-> ($past(strb.wrEn) || $past(|evtSet))); // R9

  AST_SCI_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sciLevel) |-> $past(strb.wrSts || strb.wrEn)); // R9

endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 64,
  parameter int TMR_W     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgIoBase,
  input  logic              cfgDecodeEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic              ioWide,
  input  logic [15:0]       ioWrData,
  output logic [31:0]       ioRdData,
  input  logic              evRtc,
  input  logic              evPwrBtn,
  input  logic              evGlobalLock,
  input  logic              tickEn,
  output logic              sciLevel
);

  ioStrb_t strb;

  pm_evt_ctrl #(
    .ADDR_W    (ADDR_W),
    .WIN_BYTES (WIN_BYTES),
    .SEL_BITS  (4)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgIoBase   (cfgIoBase),
    .cfgDecodeEn (cfgDecodeEn),
    .ioAddr      (ioAddr),
    .ioWrEn      (ioWrEn),
    .ioRdEn      (ioRdEn),
    .ioWide      (ioWide),
    .strb        (strb)
  );

  pm_evt_datapath #(.TMR_W(TMR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (ioWrData),
    .evRtc        (evRtc),
    .evPwrBtn     (evPwrBtn),
    .evGlobalLock (evGlobalLock),
    .tickEn       (tickEn),
    .rdData       (ioRdData),
    .sciLevel     (sciLevel)
  );

  AST_WIDE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioWide) |-> !(strb.wrSts || strb.wrEn || strb.wrCnt)); // R5

  AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && !cfgDecodeEn) |-> (ioRdData == 32'h0)); // R2

endmodule

// File: tb/pm_event_block_tb.sv
module pm_event_block_tb;

  localparam int TMR_W = 8;
  localparam int NVEC  = 15;

  typedef struct packed {
    logic        isWr;
    logic        wide;
    logic [15:0] addr;
    logic [15:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // base 0x1000, decode on, tickEn low throughout
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 16'h1002, 16'hFFFF, 32'h0,        8'd8}, // R8 enable write
    '{1'b0, 1'b0, 16'h1002, 16'h0,    32'h0000FFFF, 8'd8}, // R8
    '{1'b1, 1'b0, 16'h1004, 16'hA5C3, 32'h0,        8'd8}, // R8 control write
    '{1'b0, 1'b0, 16'h1004, 16'h0,    32'h0000A5C3, 8'd8}, // R8
    '{1'b0, 1'b0, 16'h1000, 16'h0,    32'h0,        8'd6}, // R6 no events yet
    '{1'b1, 1'b1, 16'h1002, 16'h5678, 32'h0,        8'd5}, // R5 wide write
    '{1'b0, 1'b0, 16'h1002, 16'h0,    32'h0000FFFF, 8'd5}, // R5
    '{1'b1, 1'b0, 16'h1012, 16'h0021, 32'h0,        8'd3}, // R3 alias write
    '{1'b0, 1'b0, 16'h1002, 16'h0,    32'h00000021, 8'd3}, // R3
    '{1'b0, 1'b0, 16'h1034, 16'h0,    32'h0000A5C3, 8'd3}, // R3 alias read
    '{1'b0, 1'b0, 16'h1006, 16'h0,    32'h0,        8'd4}, // R4 unmapped
    '{1'b0, 1'b1, 16'h1000, 16'h0,    32'h0,        8'd4}, // R4 wide at status
    '{1'b0, 1'b0, 16'h1040, 16'h0,    32'h0,        8'd2}, // R2 past window
    '{1'b1, 1'b0, 16'h1042, 16'h0000, 32'h0,        8'd2}, // R2 write outside
    '{1'b0, 1'b0, 16'h1002, 16'h0,    32'h00000021, 8'd2}  // R2
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgIoBase = 16'h1000;
  logic        cfgDecodeEn = 1'b1;
  logic [15:0] ioAddr = '0;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0, ioWide = 1'b0;
  logic [15:0] ioWrData = '0;
  logic [31:0] ioRdData;
  logic        evRtc = 1'b0, evPwrBtn = 1'b0, evGlobalLock = 1'b0, tickEn = 1'b0;
  logic        sciLevel;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  pm_event_block #(.TMR_W(TMR_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgIoBase(cfgIoBase), .cfgDecodeEn(cfgDecodeEn),
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioWide(ioWide),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .evRtc(evRtc), .evPwrBtn(evPwrBtn),
    .evGlobalLock(evGlobalLock), .tickEn(tickEn), .sciLevel(sciLevel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic wide, input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    ioAddr = addr; ioWide = wide; ioWrData = data; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic busRead(input logic wide, input logic [15:0] addr, output logic [31:0] data);
    @(negedge clk);
    ioAddr = addr; ioWide = wide; ioRdEn = 1'b1;
    #1 data = ioRdData;
    ioRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 sci after reset", {31'b0, sciLevel}, 32'h0);
    busRead(1'b0, 16'h1000, rd); check("R1 status reset", rd, 32'h0);
    busRead(1'b0, 16'h1002, rd); check("R1 enable reset", rd, 32'h0);
    busRead(1'b0, 16'h1004, rd); check("R1 control reset", rd, 32'h0);
    busRead(1'b1, 16'h1008, rd); check("R1 timer reset", rd, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) begin
        busWrite(VECS[i].wide, VECS[i].addr, VECS[i].data);
      end else begin
        busRead(VECS[i].wide, VECS[i].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // events and SCI; enable is 0x0021 here
    @(negedge clk); evPwrBtn = 1'b1; @(negedge clk); evPwrBtn = 1'b0;
    busRead(1'b0, 16'h1000, rd); check("R6 power button bit8", rd, 32'h0100);
    check("R9 sci low, bit8 not enabled", {31'b0, sciLevel}, 32'h0);
    @(negedge clk); evGlobalLock = 1'b1; @(negedge clk); evGlobalLock = 1'b0;
    busRead(1'b0, 16'h1000, rd); check("R6 global lock bit5", rd, 32'h0120);
    check("R9 sci high on bit5", {31'b0, sciLevel}, 32'h1);
    busWrite(1'b0, 16'h1000, 16'h0020);
    busRead(1'b0, 16'h1000, rd); check("R7 write one clears bit5", rd, 32'h0100);
    check("R9 sci low after clear", {31'b0, sciLevel}, 32'h0);
    busWrite(1'b0, 16'h1002, 16'h0100);
    check("R9 sci high after enable write", {31'b0, sciLevel}, 32'h1);
    busWrite(1'b0, 16'h1000, 16'h0000);
    busRead(1'b0, 16'h1000, rd); check("R7 write zeros keeps bits", rd, 32'h0100);
    // RTC event in the same cycle as a clear of bits 8 and 10
    @(negedge clk);
    ioAddr = 16'h1000; ioWide = 1'b0; ioWrData = 16'h0500; ioWrEn = 1'b1; evRtc = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0; evRtc = 1'b0;
    busRead(1'b0, 16'h1000, rd); check("R7 event beats clear", rd, 32'h0400);
    busWrite(1'b0, 16'h1002, 16'hFADE);
    check("R9 non-SCI enable bits give no sci", {31'b0, sciLevel}, 32'h0);
    busWrite(1'b0, 16'h1002, 16'h0400);
    check("R9 sci high on rtc bit10", {31'b0, sciLevel}, 32'h1);
    busWrite(1'b0, 16'h1000, 16'hFFFF);
    busRead(1'b0, 16'h1000, rd); check("R6 status all cleared", rd, 32'h0);

    // decode enable and base
    cfgDecodeEn = 1'b0;
    busRead(1'b0, 16'h1002, rd); check("R2 read with decode off", rd, 32'h0);
    busWrite(1'b0, 16'h1002, 16'hFFFF);
    cfgDecodeEn = 1'b1;
    busRead(1'b0, 16'h1002, rd); check("R2 write with decode off ignored", rd, 32'h0400);
    cfgIoBase = 16'h1234;
    busRead(1'b0, 16'h1202, rd); check("R2 masked base", rd, 32'h0400);
    busRead(1'b0, 16'h1002, rd); check("R2 old base dead", rd, 32'h0);
    cfgIoBase = 16'h1000;

    // timer
    busWrite(1'b0, 16'h1002, 16'h0001);
    ticks(5);
    busRead(1'b1, 16'h1008, rd); check("R10 timer count 5", rd, 32'd5);
    busRead(1'b0, 16'h1008, rd); check("R4 narrow read at timer offset", rd, 32'h0);
    ticks(250);
    busRead(1'b1, 16'h1008, rd); check("R10 timer at max", rd, 32'hFF);
    busRead(1'b0, 16'h1000, rd); check("R10 no status before carry", rd, 32'h0);
    ticks(1);
    busRead(1'b1, 16'h1008, rd); check("R10 timer wraps", rd, 32'h0);
    busRead(1'b0, 16'h1000, rd); check("R10 carry sets bit0", rd, 32'h0001);
    check("R9 sci on timer carry", {31'b0, sciLevel}, 32'h1);
    busWrite(1'b0, 16'h1000, 16'h0001);
    check("R7 timer status cleared, sci low", {31'b0, sciLevel}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule